// File: doc/BRIEF.md
# Speculative Response Frame Transmitter

This block sends an Ethernet response frame before it knows whether the response is wanted. A start request arrives as soon as a possibly triggering input frame begins to come in. The block then emits the preamble and start-of-frame delimiter, followed by a prebuilt header template taken from a host-written byte memory. That template holds the stacked Ethernet, IPv4, TCP and FIX headers. A separate rule engine on a slower host decides whether the input frame matches, and this block only reacts to the result.

A match strobe latches a parallel bus of order fields. Those bytes follow the header at once, and then comes a correct CRC-32 frame check sequence. A no-match strobe ends the frame with the bitwise inverse of the correct check value, so the receiver drops it. If the template has been fully sent and no result has arrived yet, the output is held invalid and the frame stays open until a result comes. Decision strobes seen while idle are flagged, and start requests seen while busy are counted.

Top module: `spec_tx`

## Requirements
- R1: After reset `tx_valid`, `orphan_err` and `drop_count` are all zero.
- R2: Every frame opens with seven bytes of 0x55 and then one byte of 0xD5. `tx_first` is high on the first 0x55 byte only.
- R3: After the delimiter, template bytes at addresses 0 to `hdr_len`-1 are sent in address order, whether or not a decision has arrived. A length above the template depth is clamped to the depth.
- R4: On a match, the PAY_BYTES bytes of `match_fields` follow the header, least-significant byte (bits 7:0) first. If the decision arrives before the header is done, no invalid cycle appears anywhere in the frame.
- R5: A matched frame ends with four check bytes. They are the CRC-32 over the header and payload bytes (reflected polynomial 0x04C11DB7, initial value all ones, final inversion), sent least-significant byte first. `tx_last` is high on the final check byte only.
- R6: On a no-match, no payload is sent. The four check bytes are the bitwise inverse of the correct CRC-32 over the header bytes. If both strobes are high in the same cycle, no-match wins.
- R7: If the header has been sent and no decision is held, `tx_valid` stays low and the frame stays open. A decision in cycle t makes `tx_valid` high again in cycle t+1.
- R8: While `tx_valid` is high and `tx_ready` is low, the byte on `tx_data` and the flags are held and nothing advances.
- R9: A decision strobe seen while no frame is in progress has no effect on the output and sets the sticky flag `orphan_err`.
- R10: A start request seen while a frame is in progress is dropped. It increments `drop_count`, which saturates at 0xFFFF.
- R11: Only the first decision within a frame counts. Later strobes in the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tpl_we | input | 1 | Template byte write enable |
| tpl_waddr | input | 7 | Template write address |
| tpl_wdata | input | 8 | Template write data |
| hdr_len | input | 8 | Header template length in bytes, sampled at start |
| start_req | input | 1 | Begin a speculative frame |
| match_stb | input | 1 | Match result strobe |
| nomatch_stb | input | 1 | No-match result strobe |
| match_fields | input | 256 | Order field bytes, latched on the match strobe |
| tx_ready | input | 1 | Sink accepts the current byte |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Last byte of frame |
| orphan_err | output | 1 | Sticky: decision seen while idle |
| drop_count | output | 16 | Saturating count of dropped start requests |

## Verification
Header length is swept over every value from zero to the template depth. For each length the bench tries a match and a no-match, with the decision either early or after the header has finished. The early case must give a frame with no gaps. The late case must give exactly the predicted number of invalid cycles, which separates speculative streaming from waiting on the decision. The bench also runs frames with a periodic `tx_ready` stall to expose skipped or repeated bytes, simultaneous and conflicting strobes to fix the priority, and decisions while idle. Finally it sends a long burst of start requests into an open frame to reach the counter's saturation point.

// File: rtl/spec_tx_pkg.sv
package spec_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_WAIT,
        ST_PAY,
        ST_FCS
    } tx_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam int          PRE_LEN       = 8;
    localparam int          FCS_LEN       = 4;
endpackage

// File: rtl/spec_tx_tpl_ram.sv
module spec_tx_tpl_ram #(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spec_tx_crc_step.sv
module spec_tx_crc_step
    import spec_tx_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    always_comb begin
        logic [31:0] c;
        c = crc_in ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/spec_tx.sv
module spec_tx
    import spec_tx_pkg::*;
#(
    parameter int TPL_DEPTH = 128,
    parameter int PAY_BYTES = 32,
    localparam int AW  = (TPL_DEPTH > 1) ? $clog2(TPL_DEPTH) : 1,
    localparam int LW  = $clog2(TPL_DEPTH + 1),
    localparam int PW  = PAY_BYTES * 8,
    localparam int IW  = $clog2(TPL_DEPTH + PAY_BYTES + PRE_LEN + 1),
    localparam int PIW = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tpl_we,
    input  logic [AW-1:0] tpl_waddr,
    input  logic [7:0]    tpl_wdata,
    input  logic [LW-1:0] hdr_len,
    input  logic          start_req,
    input  logic          match_stb,
    input  logic          nomatch_stb,
    input  logic [PW-1:0] match_fields,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_first,
    output logic          tx_last,
    output logic          orphan_err,
    output logic [15:0]   drop_count
);
    typedef struct packed {
        tx_state_e     st;
        logic [IW-1:0] idx;
        logic [LW-1:0] len;
        logic          decided;
        logic          good;
        logic [PW-1:0] pay;
        logic [31:0]   crc;
        logic          err;
        logic [15:0]   drops;
    } regs_t;

    regs_t r_q, r_d;

    logic [7:0]  tpl_byte;
    logic [31:0] crc_next;
    logic [31:0] fcs_word;
    logic [7:0]  pay_bytes [PAY_BYTES];

    spec_tx_tpl_ram #(.DEPTH(TPL_DEPTH)) u_tpl (
        .clk     (clk),
        .wr_en   (tpl_we),
        .wr_addr (tpl_waddr),
        .wr_data (tpl_wdata),
        .rd_addr (r_q.idx[AW-1:0]),
        .rd_data (tpl_byte)
    );

    spec_tx_crc_step u_crc (
        .crc_in  (r_q.crc),
        .data    (tx_data),
        .crc_out (crc_next)
    );

    for (genvar g = 0; g < PAY_BYTES; g++) begin : g_pay
        assign pay_bytes[g] = r_q.pay[g*8 +: 8];
    end

    // Good frame: inverted register; poisoned frame: the inverse of that.
    assign fcs_word = r_q.good ? ~r_q.crc : r_q.crc;

    always_comb begin
        tx_data = 8'h00;
        unique case (r_q.st)
            ST_PRE:  tx_data = (r_q.idx == IW'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
            ST_HDR:  tx_data = tpl_byte;
            ST_PAY:  tx_data = pay_bytes[r_q.idx[PIW-1:0]];
            ST_FCS:  tx_data = fcs_word[r_q.idx[1:0]*8 +: 8];
            default: tx_data = 8'h00;
        endcase
    end

    assign tx_valid   = (r_q.st == ST_PRE) || (r_q.st == ST_HDR) ||
                        (r_q.st == ST_PAY) || (r_q.st == ST_FCS);
    assign tx_first   = (r_q.st == ST_PRE) && (r_q.idx == '0);
    assign tx_last    = (r_q.st == ST_FCS) && (r_q.idx == IW'(FCS_LEN - 1));
    assign orphan_err = r_q.err;
    assign drop_count = r_q.drops;

    logic      busy, fire, dec_any, take_dec, eff_dec, eff_good;
    tx_state_e post_hdr;

    always_comb begin
        r_d      = r_q;
        busy     = (r_q.st != ST_IDLE);
        fire     = tx_valid && tx_ready;
        dec_any  = match_stb || nomatch_stb;
        take_dec = dec_any && !r_q.decided &&
                   ((r_q.st == ST_PRE) || (r_q.st == ST_HDR) || (r_q.st == ST_WAIT));
        eff_dec  = r_q.decided || take_dec;
        eff_good = r_q.decided ? r_q.good : !nomatch_stb;
        post_hdr = !eff_dec ? ST_WAIT : (eff_good ? ST_PAY : ST_FCS);

        if (dec_any && !busy) begin
            r_d.err = 1'b1;
        end
        if (take_dec) begin
            r_d.decided = 1'b1;
            r_d.good    = !nomatch_stb;
            r_d.pay     = match_fields;
        end
        if (start_req && busy && (r_q.drops != 16'hFFFF)) begin
            r_d.drops = r_q.drops + 16'd1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    r_d.st      = ST_PRE;
                    r_d.idx     = '0;
                    r_d.len     = (hdr_len > LW'(TPL_DEPTH)) ? LW'(TPL_DEPTH) : hdr_len;
                    r_d.decided = 1'b0;
                    r_d.good    = 1'b0;
                    r_d.crc     = '1;
                end
            end
            ST_PRE: begin
                if (fire) begin
                    if (r_q.idx == IW'(PRE_LEN - 1)) begin
                        r_d.idx = '0;
                        r_d.st  = (r_q.len == '0) ? post_hdr : ST_HDR;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (fire) begin
                    r_d.crc = crc_next;
                    if (r_q.idx == IW'(r_q.len) - 1'b1) begin
                        r_d.idx = '0;
                        r_d.st  = post_hdr;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (eff_dec) begin
                    r_d.idx = '0;
                    r_d.st  = eff_good ? ST_PAY : ST_FCS;
                end
            end
            ST_PAY: begin
                if (fire) begin
                    r_d.crc = crc_next;
                    if (r_q.idx == IW'(PAY_BYTES - 1)) begin
                        r_d.idx = '0;
                        r_d.st  = ST_FCS;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_FCS: begin
                if (fire) begin
                    if (r_q.idx == IW'(FCS_LEN - 1)) begin
                        r_d.idx = '0;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.crc   <= '1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/spec_tx_chk.sv
module spec_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_first,
    input logic        tx_last,
    input logic        orphan_err,
    input logic [15:0] drop_count
);
    // R2: a frame opens on a preamble byte
    p_first_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_first |-> (tx_valid && tx_data == 8'h55));

    // R8: a stalled byte is held
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                     $stable(tx_first) && $stable(tx_last)));

    // R5: an accepted last byte closes the frame
    p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last && tx_ready) |=> !tx_valid);

    // R9: the orphan flag never clears outside reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        orphan_err |=> orphan_err);

    // R10: the drop counter only holds or steps by one
    p_drop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((drop_count == $past(drop_count)) ||
                  (drop_count == 16'($past(drop_count) + 16'd1))));
endmodule

bind spec_tx spec_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_first   (tx_first),
    .tx_last    (tx_last),
    .orphan_err (orphan_err),
    .drop_count (drop_count)
);

// File: tb/spec_tx_bench.sv
module spec_tx_bench;
    localparam int DEPTH = 16;
    localparam int PAYB  = 4;
    localparam int AW    = 4;
    localparam int LW    = 5;
    localparam int PW    = PAYB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tpl_we = 1'b0;
    logic [AW-1:0] tpl_waddr = '0;
    logic [7:0]    tpl_wdata = '0;
    logic [LW-1:0] hdr_len = '0;
    logic          start_req = 1'b0;
    logic          match_stb = 1'b0;
    logic          nomatch_stb = 1'b0;
    logic [PW-1:0] match_fields = '0;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data;
    logic          tx_valid, tx_first, tx_last, orphan_err;
    logic [15:0]   drop_count;

    spec_tx #(.TPL_DEPTH(DEPTH), .PAY_BYTES(PAYB)) u_spec_tx (
        .clk(clk), .rst_n(rst_n), .tpl_we(tpl_we), .tpl_waddr(tpl_waddr),
        .tpl_wdata(tpl_wdata), .hdr_len(hdr_len), .start_req(start_req),
        .match_stb(match_stb), .nomatch_stb(nomatch_stb),
        .match_fields(match_fields), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
        .orphan_err(orphan_err), .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit bp_on = 1'b0;

    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        tx_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual cycle %0d expected below 190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Output capture
    logic [7:0] rx_b [128];
    bit         rx_f [128];
    bit         rx_l [128];
    int         n_rx = 0;
    int         gaps = 0;
    bit         in_frame = 1'b0;
    bit         done = 1'b0;

    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            if (n_rx < 128) begin
                rx_b[n_rx] = tx_data;
                rx_f[n_rx] = tx_first;
                rx_l[n_rx] = tx_last;
            end
            n_rx = n_rx + 1;
            in_frame = !tx_last;
            if (tx_last) done = 1'b1;
        end else if (in_frame && !tx_valid) begin
            gaps = gaps + 1;
        end
    end

    logic [7:0] tpl_m [DEPTH];
    logic [7:0] exp_b [128];
    int         n_exp;

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, expv, expv);
        end
    endtask

    task automatic build_exp(input int len, input bit good, input logic [PW-1:0] f);
        logic [31:0] c;
        logic [31:0] fcs;
        c = 32'hFFFF_FFFF;
        n_exp = 0;
        for (int i = 0; i < 7; i++) begin exp_b[n_exp] = 8'h55; n_exp++; end
        exp_b[n_exp] = 8'hD5; n_exp++;
        for (int i = 0; i < len; i++) begin
            exp_b[n_exp] = tpl_m[i]; c = crc_byte(c, tpl_m[i]); n_exp++;
        end
        if (good) begin
            for (int i = 0; i < PAYB; i++) begin
                exp_b[n_exp] = f[i*8 +: 8]; c = crc_byte(c, f[i*8 +: 8]); n_exp++;
            end
        end
        fcs = good ? ~c : c;
        for (int i = 0; i < 4; i++) begin exp_b[n_exp] = fcs[i*8 +: 8]; n_exp++; end
    endtask

    task automatic compare(input string body_req);
        int bad_i;
        int flag_bad;
        bad_i = -1;
        flag_bad = 0;
        check(n_rx == n_exp, "R3", "frame length", n_rx, n_exp);
        if (n_rx == n_exp) begin
            for (int i = 0; i < n_exp; i++) begin
                if (bad_i < 0 && rx_b[i] !== exp_b[i]) bad_i = i;
                if (rx_f[i] != (i == 0) || rx_l[i] != (i == n_exp - 1)) flag_bad = 1;
            end
            check(bad_i < 0, body_req, "frame byte",
                  (bad_i < 0) ? 0 : int'(rx_b[bad_i]), (bad_i < 0) ? 0 : int'(exp_b[bad_i]));
            check(flag_bad == 0, "R2 R5", "first/last flags", flag_bad, 0);
        end
    endtask

    task automatic wait_done;
        for (int t = 0; t < 600 && !done; t++) @(negedge clk);
        check(done, "R5", "frame completed", done, 1);
    endtask

    task automatic begin_frame(input int len, input logic [PW-1:0] f);
        n_rx = 0; gaps = 0; done = 1'b0; in_frame = 1'b0;
        @(posedge clk); #2;
        hdr_len = LW'(len);
        match_fields = f;
        start_req = 1'b1;
        @(posedge clk); #2;
        start_req = 1'b0;
    endtask

    // mode: 0 match, 1 nomatch, 2 both same cycle, 3 match then nomatch
    task automatic run_frame(input int len, input int mode, input int dly, input bit bp);
        logic [PW-1:0] f;
        bit good;
        int exp_gap;
        f = PW'(32'hA5C3_0001 * (len + 7) + mode * 13 + dly);
        good = (mode == 0) || (mode == 3);
        bp_on = bp;
        begin_frame(len, f);
        repeat (dly - 1) @(posedge clk);
        #2;
        match_stb   = (mode != 1);
        nomatch_stb = (mode == 1) || (mode == 2);
        @(posedge clk); #2;
        match_stb = 1'b0;
        nomatch_stb = (mode == 3);
        @(posedge clk); #2;
        nomatch_stb = 1'b0;
        wait_done();
        bp_on = 1'b0;
        build_exp(len, good, f);
        compare(good ? ((mode == 3) ? "R11" : "R4") : "R6");
        if (!bp) begin
            exp_gap = (dly > 8 + len) ? dly - 8 - len : 0;
            check(gaps == exp_gap, (exp_gap == 0) ? "R4" : "R7", "idle cycles in frame",
                  gaps, exp_gap);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) tpl_m[i] = 8'((i * 37 + 5) ^ (i << 4));
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            tpl_we = 1'b1; tpl_waddr = AW'(i); tpl_wdata = tpl_m[i];
            @(posedge clk); #2;
        end
        tpl_we = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_valid == 0, "R1", "tx_valid after reset", tx_valid, 0);
        check(orphan_err == 0, "R1", "orphan_err after reset", orphan_err, 0);
        check(drop_count == 0, "R1", "drop_count after reset", drop_count, 0);

        // Sweep header length, decision type and timing
        for (int len = 0; len <= DEPTH; len++) begin
            run_frame(len, 0, 1, 1'b0);
            run_frame(len, 1, 1, 1'b0);
            run_frame(len, 0, len + 8, 1'b0);
            run_frame(len, 0, len + 12, 1'b0);
            run_frame(len, 1, len + 11, 1'b0);
        end
        // R8 stalls, R6 priority, R11 first decision wins
        for (int len = 0; len <= DEPTH; len += 3) begin
            run_frame(len, 0, 2, 1'b1);
            run_frame(len, 1, len + 20, 1'b1);
            run_frame(len, 2, 3, 1'b0);
            run_frame(len, 3, 2, 1'b0);
        end
        // R3 oversize length is clamped to the depth
        begin
            logic [PW-1:0] f;
            f = 32'h1234_5678;
            begin_frame(DEPTH + 9, f);
            match_stb = 1'b1;
            @(posedge clk); #2;
            match_stb = 1'b0;
            wait_done();
            build_exp(DEPTH, 1'b1, f);
            compare("R3");
        end

        // R7 and R10: hold a frame open, flood start requests
        begin
            logic [PW-1:0] f;
            f = 32'hCAFE_0B0E;
            begin_frame(2, f);
            repeat (14) @(negedge clk);
            check(tx_valid == 0 && !done, "R7", "frame held open without decision",
                  {tx_valid, done}, 0);
            @(posedge clk); #2;
            start_req = 1'b1;
            repeat (3) @(posedge clk);
            #2;
            start_req = 1'b0;
            @(negedge clk);
            check(drop_count == 16'd3, "R10", "drop count after three", drop_count, 3);
            @(posedge clk); #2;
            start_req = 1'b1;
            repeat (65540) @(posedge clk);
            #2;
            start_req = 1'b0;
            @(negedge clk);
            check(drop_count == 16'hFFFF, "R10", "drop count saturates", drop_count, 16'hFFFF);
            @(posedge clk); #2;
            match_stb = 1'b1;
            @(posedge clk); #2;
            match_stb = 1'b0;
            @(negedge clk);
            check(tx_valid == 1, "R7", "resume one cycle after decision", tx_valid, 1);
            wait_done();
            build_exp(2, 1'b1, f);
            compare("R10");
        end

        // R9 orphan decision while idle
        repeat (3) @(posedge clk);
        check(orphan_err == 0, "R9", "no orphan flag before idle strobe", orphan_err, 0);
        n_rx = 0;
        @(posedge clk); #2;
        match_stb = 1'b1;
        @(posedge clk); #2;
        match_stb = 1'b0;
        repeat (4) @(negedge clk);
        check(orphan_err == 1, "R9", "orphan flag set", orphan_err, 1);
        check(n_rx == 0 && tx_valid == 0, "R9", "no output from idle strobe", n_rx, 0);
        @(posedge clk); #2;
        nomatch_stb = 1'b1;
        @(posedge clk); #2;
        nomatch_stb = 1'b0;
        run_frame(4, 0, 1, 1'b0);
        check(orphan_err == 1, "R9", "orphan flag sticky", orphan_err, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule